// File: doc/BRIEF.md
# Converter Serial Result Port

This block is the digital side of a 16-bit sampling converter that is read in four-wire select mode. A convert strobe starts a timed conversion; once the timer expires the result word, supplied here on a parallel input in place of the analog core, is captured and the block powers down into acquisition. A host then pulls the active-low select input low to read the word MSB first on a serial output, advancing one bit per falling serial clock edge. The serial output is modelled as a data bit plus an output enable, where a low enable means high impedance, so several such blocks can share one data line with a separate select each.

All three control inputs are brought into the system clock domain through a synchronizer, and every decision is made on edges found there. The mode is taken from the select level seen at the convert rising edge. Only the select-high case, which starts a conversion, is handled. A convert rise with select low belongs to modes this block does not implement and is dropped.

The controller has five states. IDLE is the state after reset, before any result exists. CONVERT runs the conversion timer. ACQUIRE holds a result and waits in low power. SHIFT drives the word out. DONE is entered after all bits have gone out and keeps the line released. The transitions are as follows. IDLE, ACQUIRE and DONE go to CONVERT on a convert rise with select high. CONVERT goes to ACQUIRE on timer expiry. ACQUIRE goes to SHIFT on a select fall. SHIFT goes to DONE on the sixteenth serial clock fall. SHIFT and DONE go back to ACQUIRE on a select rise.

Top module: `serial_result_port`

## Requirements
- R1: After reset the output enable is low and the controller is in IDLE.
- R2: A convert rise while select is high starts a conversion. While convert stays high during the conversion, the output enable stays low.
- R3: A convert rise while select is low starts no conversion, and a result already held is kept.
- R4: A conversion lasts exactly CONV_CYCLES clocks. At its last edge the word on result_i is captured. A select fall seen on that last edge is ignored, and one seen a clock later starts a read.
- R5: In ACQUIRE a select fall enables the output and presents bit 15 of the held word.
- R6: Each falling serial clock edge during a read moves the output to the next lower bit.
- R7: After the sixteenth falling serial clock edge the output enable goes low and stays low until select rises.
- R8: A select rise during or after a read releases the output at once and resets the bit count. The next select fall restarts the same word at bit 15.
- R9: Whenever synchronized convert and select are both low, the output is enabled and drives 0, overriding data.
- R10: A convert rise during a conversion neither restarts nor lengthens it.
- R11: Every input change reaches the outputs through exactly three clock edges: two synchronizer flops and one edge-detect register.
- R12: In IDLE, with convert high, a select fall leaves the output disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnv_i | input | 1 | Convert strobe, asynchronous |
| sel_n_i | input | 1 | Active-low select and mode input, asynchronous |
| sclk_i | input | 1 | Serial clock from the host, asynchronous |
| result_i | input | DATA_W | Parallel result captured at the end of conversion |
| sdo_o | output | 1 | Serial data bit |
| sdo_oe_o | output | 1 | Serial data enable; low means high impedance |

## Verification
An input change made between two clock edges shows at the outputs after the third rising edge that follows. The bench drives inputs on falling edges and checks directed expectations three falling edges after each change; it also checks one edge earlier, where nothing may have moved yet. A conversion started by an input change therefore ends CONV_CYCLES plus three edges after that change. The bench places a select fall one clock each side of that point. A behavioural model counts the same delays with its own variables and is compared with both outputs on every falling edge.

// File: rtl/srp_pkg.sv
package srp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_CONVERT = 3'd1,
        ST_ACQUIRE = 3'd2,
        ST_SHIFT   = 3'd3,
        ST_DONE    = 3'd4
    } srp_state_e;

    localparam int unsigned PIN_CNV   = 0;
    localparam int unsigned PIN_SEL   = 1;
    localparam int unsigned PIN_SCLK  = 2;
    localparam int unsigned PIN_COUNT = 3;

endpackage

// File: rtl/srp_sync_edge.sv
module srp_sync_edge #(
    parameter int unsigned          WIDTH   = 3,
    parameter int unsigned          STAGES  = 2,
    parameter logic [WIDTH-1:0]     RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] sync,
    output logic [WIDTH-1:0] level
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        logic              prev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q[0] <= RST_VAL[b];
            end else begin
                chain_q[0] <= din[b];
            end
        end

        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[s] <= RST_VAL[b];
                end else begin
                    chain_q[s] <= chain_q[s-1];
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q <= RST_VAL[b];
            end else begin
                prev_q <= chain_q[STAGES-1];
            end
        end

        assign sync[b]  = chain_q[STAGES-1];
        assign level[b] = prev_q;
    end

endmodule

// File: rtl/srp_conv_timer.sv
module srp_conv_timer #(
    parameter int unsigned CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic done
);

    localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CW'(CYCLES - 1);
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/srp_shifter.sv
module srp_shifter #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [WIDTH-1:0] din,
    input  logic             load,
    input  logic             shift,
    input  logic             clear,
    output logic             msb,
    output logic             last
);

    localparam int unsigned CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

    logic [WIDTH-1:0] hold_q;
    logic [WIDTH-1:0] shift_q;
    logic [CW-1:0]    cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (capture) begin
            hold_q <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
            cnt_q   <= '0;
        end else if (load) begin
            shift_q <= hold_q;
            cnt_q   <= '0;
        end else if (clear) begin
            cnt_q   <= '0;
        end else if (shift) begin
            shift_q <= {shift_q[WIDTH-2:0], 1'b0};
            cnt_q   <= cnt_q + CW'(1);
        end
    end

    assign msb  = shift_q[WIDTH-1];
    assign last = (cnt_q == CW'(WIDTH - 1));

endmodule

// File: rtl/serial_result_port.sv
module serial_result_port
    import srp_pkg::*;
#(
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned CONV_CYCLES = 40,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnv_i,
    input  logic              sel_n_i,
    input  logic              sclk_i,
    input  logic [DATA_W-1:0] result_i,
    output logic              sdo_o,
    output logic              sdo_oe_o
);

    localparam logic [PIN_COUNT-1:0] PIN_RST = PIN_COUNT'(1) << PIN_SEL;

    logic [PIN_COUNT-1:0] pins;
    logic [PIN_COUNT-1:0] pin_sync;
    logic [PIN_COUNT-1:0] pin_lvl;

    logic cnv_lvl, sel_lvl;
    logic cnv_rise, sel_rise, sel_fall, sclk_fall;
    logic conv_done, last_bit, shift_msb;
    logic start_conv, capture, load, shift_en;

    srp_state_e state_q, state_d;

    assign pins[PIN_CNV]  = cnv_i;
    assign pins[PIN_SEL]  = sel_n_i;
    assign pins[PIN_SCLK] = sclk_i;

    srp_sync_edge #(
        .WIDTH   (PIN_COUNT),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pins),
        .sync  (pin_sync),
        .level (pin_lvl)
    );

    assign cnv_lvl   = pin_lvl[PIN_CNV];
    assign sel_lvl   = pin_lvl[PIN_SEL];
    assign cnv_rise  =  pin_sync[PIN_CNV]  & ~pin_lvl[PIN_CNV];
    assign sel_rise  =  pin_sync[PIN_SEL]  & ~pin_lvl[PIN_SEL];
    assign sel_fall  = ~pin_sync[PIN_SEL]  &  pin_lvl[PIN_SEL];
    assign sclk_fall = ~pin_sync[PIN_SCLK] &  pin_lvl[PIN_SCLK];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cnv_rise && sel_lvl) begin
                    state_d = ST_CONVERT;
                end
            end
            ST_CONVERT: begin
                if (conv_done) begin
                    state_d = ST_ACQUIRE;
                end
            end
            ST_ACQUIRE: begin
                if (cnv_rise && sel_lvl) begin
                    state_d = ST_CONVERT;
                end else if (sel_fall) begin
                    state_d = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (sel_rise) begin
                    state_d = ST_ACQUIRE;
                end else if (sclk_fall && last_bit) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                if (sel_rise) begin
                    state_d = ST_ACQUIRE;
                end else if (cnv_rise && sel_lvl) begin
                    state_d = ST_CONVERT;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign start_conv = (state_q != ST_CONVERT) && (state_d == ST_CONVERT);
    assign capture    = (state_q == ST_CONVERT) && conv_done;
    assign load       = (state_q == ST_ACQUIRE) && (state_d == ST_SHIFT);
    assign shift_en   = (state_q == ST_SHIFT) && sclk_fall && !sel_rise;

    srp_conv_timer #(
        .CYCLES (CONV_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start_conv),
        .run   (state_q == ST_CONVERT),
        .done  (conv_done)
    );

    srp_shifter #(
        .WIDTH (DATA_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .din     (result_i),
        .load    (load),
        .shift   (shift_en),
        .clear   (sel_rise),
        .msb     (shift_msb),
        .last    (last_bit)
    );

    // outputs
    always_comb begin
        sdo_oe_o = 1'b0;
        sdo_o    = 1'b0;
        if (state_q == ST_SHIFT) begin
            sdo_oe_o = 1'b1;
            sdo_o    = cnv_lvl & shift_msb;
        end
        if (!cnv_lvl && !sel_lvl) begin
            sdo_oe_o = 1'b1;
            sdo_o    = 1'b0;
        end
    end

endmodule

// File: rtl/srp_checker.sv
module srp_checker
    import srp_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input srp_state_e state_q,
    input logic       cnv_lvl,
    input logic       sel_lvl,
    input logic       cnv_rise,
    input logic       sel_rise,
    input logic       sel_fall,
    input logic       sclk_fall,
    input logic       conv_done,
    input logic       last_bit,
    input logic       sdo_o,
    input logic       sdo_oe_o
);

    assert_conv_hiz_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONVERT && cnv_lvl) |-> !sdo_oe_o);

    assert_no_mode_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnv_rise && !sel_lvl && state_q != ST_CONVERT) |=> state_q != ST_CONVERT);

    assert_conv_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONVERT && conv_done) |=> state_q == ST_ACQUIRE);

    assert_conv_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONVERT && !conv_done) |=> state_q == ST_CONVERT);

    assert_read_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACQUIRE && sel_fall && !(cnv_rise && sel_lvl))
        |=> (state_q == ST_SHIFT && sdo_oe_o));

    assert_last_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && sclk_fall && last_bit && !sel_rise)
        |=> (state_q == ST_DONE && !sdo_o));

    assert_deselect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_rise && (state_q == ST_SHIFT || state_q == ST_DONE))
        |=> state_q == ST_ACQUIRE);

    assert_drive_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnv_lvl && !sel_lvl) |-> (sdo_oe_o && !sdo_o));

endmodule

bind serial_result_port srp_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_q   (state_q),
    .cnv_lvl   (cnv_lvl),
    .sel_lvl   (sel_lvl),
    .cnv_rise  (cnv_rise),
    .sel_rise  (sel_rise),
    .sel_fall  (sel_fall),
    .sclk_fall (sclk_fall),
    .conv_done (conv_done),
    .last_bit  (last_bit),
    .sdo_o     (sdo_o),
    .sdo_oe_o  (sdo_oe_o)
);

// File: tb/test_serial_result_port.sv
module test_serial_result_port;

    localparam int CONV = 24;
    localparam logic [15:0] W1 = 16'hA5C3;
    localparam logic [15:0] W2 = 16'h3C96;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnv = 1'b0;
    logic        sel_n = 1'b1;
    logic        sclk = 1'b0;
    logic [15:0] res = 16'h0000;
    logic        sdo, sdo_oe;

    int total = 0;
    int bad = 0;
    bit over = 0;

    always #10 clk = ~clk;

    serial_result_port #(
        .DATA_W      (16),
        .CONV_CYCLES (CONV),
        .SYNC_STAGES (2)
    ) i_serial_result_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnv_i    (cnv),
        .sel_n_i  (sel_n),
        .sclk_i   (sclk),
        .result_i (res),
        .sdo_o    (sdo),
        .sdo_oe_o (sdo_oe)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse();
        sclk = 1'b1; step(3);
        sclk = 1'b0; step(3);
    endtask

    // behavioural reference: three-edge input delay, phase by integer code
    bit c1, c2, c3, s1, s2, s3, k1, k2, k3;
    int mph, remain, nbits;
    logic [15:0] mhold, mword;
    bit eoe, edat;

    always @(posedge clk) begin
        bit cr, sr, sf, kf;
        if (!rst_n) begin
            {c1, c2, c3} = 3'b000;
            {s1, s2, s3} = 3'b111;
            {k1, k2, k3} = 3'b000;
            mph = 0; remain = 0; nbits = 0;
            mhold = '0; mword = '0;
        end else begin
            cr = c2 && !c3;
            sr = s2 && !s3;
            sf = !s2 && s3;
            kf = !k2 && k3;
            case (mph)
                0: if (cr && s3) begin mph = 1; remain = CONV; end
                1: begin
                    remain--;
                    if (remain == 0) begin mhold = res; mph = 2; end
                end
                2: if (cr && s3) begin mph = 1; remain = CONV; end
                   else if (sf) begin mword = mhold; nbits = 0; mph = 3; end
                3: if (sr) mph = 2;
                   else if (kf) begin
                       mword = mword << 1;
                       nbits++;
                       if (nbits == 16) mph = 4;
                   end
                4: if (sr) mph = 2;
                   else if (cr && s3) begin mph = 1; remain = CONV; end
                default: mph = 0;
            endcase
            c3 = c2; c2 = c1; c1 = cnv;
            s3 = s2; s2 = s1; s1 = sel_n;
            k3 = k2; k2 = k1; k1 = sclk;
        end
        eoe  = (mph == 3) || (!c3 && !s3);
        edat = (mph == 3 && c3) ? mword[15] : 1'b0;
    end

    always @(negedge clk) begin
        if (rst_n && !over) begin
            chk("R11 cycle enable", 16'(sdo_oe), 16'(eoe));
            chk("R11 cycle data", 16'(sdo), 16'(edat));
        end
    end

    initial begin
        step(4);
        rst_n = 1'b1;
        step(1);
        chk("R1 reset enable", 16'(sdo_oe), 16'd0);

        sel_n = 1'b0; step(3);
        chk("R9 idle drive-low enable", 16'(sdo_oe), 16'd1);
        chk("R9 idle drive-low data", 16'(sdo), 16'd0);
        cnv = 1'b1; step(3);
        chk("R12 idle select no data", 16'(sdo_oe), 16'd0);
        sel_n = 1'b1; step(3);
        cnv = 1'b0; step(3);

        // conversion A with an extra convert edge inside (R10)
        res = W1;
        cnv = 1'b1; step(3);
        chk("R2 conversion hiz", 16'(sdo_oe), 16'd0);
        step(2);
        cnv = 1'b0; step(3);
        cnv = 1'b1; step(CONV - 8);
        step(1);
        sel_n = 1'b0; step(2);
        chk("R11 not yet enabled", 16'(sdo_oe), 16'd0);
        res = 16'hFFFF;
        step(1);
        chk("R5 read enable", 16'(sdo_oe), 16'd1);
        chk("R10 R5 msb", 16'(sdo), 16'(W1[15]));
        for (int k = 1; k < 16; k++) begin
            pulse();
            chk("R6 shifted bit", 16'(sdo), 16'(W1[15-k]));
        end
        pulse();
        chk("R7 released after 16", 16'(sdo_oe), 16'd0);

        cnv = 1'b0; step(3);
        chk("R9 done drive-low", 16'(sdo_oe), 16'd1);
        cnv = 1'b1; step(3);
        chk("R3 done no conversion", 16'(sdo_oe), 16'd0);
        sel_n = 1'b1; step(3);
        sel_n = 1'b0; step(3);
        chk("R3 word kept enable", 16'(sdo_oe), 16'd1);
        chk("R3 word kept msb", 16'(sdo), 16'(W1[15]));
        for (int k = 0; k < 5; k++) pulse();
        chk("R6 bit 10", 16'(sdo), 16'(W1[10]));
        sel_n = 1'b1; step(3);
        chk("R8 early release", 16'(sdo_oe), 16'd0);
        sel_n = 1'b0; step(3);
        chk("R8 restart msb", 16'(sdo), 16'(W1[15]));
        cnv = 1'b0; step(3);
        chk("R9 override data", 16'(sdo), 16'd0);
        chk("R9 override enable", 16'(sdo_oe), 16'd1);
        cnv = 1'b1; step(3);
        chk("R3 shift rise ignored", 16'(sdo), 16'(W1[15]));
        sel_n = 1'b1; step(3);

        // conversion B: select fall on the final conversion edge is ignored
        res = W2;
        cnv = 1'b0; step(3);
        cnv = 1'b1; step(CONV);
        sel_n = 1'b0; step(4);
        chk("R4 fall at last edge ignored", 16'(sdo_oe), 16'd0);
        sel_n = 1'b1; step(4);
        res = 16'hFFFF;
        sel_n = 1'b0; step(3);
        chk("R4 captured enable", 16'(sdo_oe), 16'd1);
        chk("R4 captured msb", 16'(sdo), 16'(W2[15]));
        pulse();
        chk("R4 captured bit 14", 16'(sdo), 16'(W2[14]));
        sel_n = 1'b1; step(5);

        if (!over) begin
            over = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!over) begin
            over = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule